// File: doc/BRIEF.md
# SHA-512 Message Schedule Sigma0 Unit

This datapath unit computes the first half of a four-word step of the SHA-512 message schedule. A 256-bit operand carries four consecutive 64-bit message words, and the low 64-bit word of a separate 128-bit operand carries the word that follows them. In each of the four 64-bit lanes, the unit adds the lane's own word to the small-sigma-0 of the next word up. The top lane takes its neighbour from the narrow operand.

The four results form a 256-bit value that replaces the wide operand. This makes the unit a read-modify-write step on the wide source. The sigma1 half of the schedule, the compression rounds and any register file are outside this block.

The unit sits in an execution pipeline behind a valid/ready handshake. An operand pair is taken when `in_valid` and `in_ready` are both high. The sum is registered and presented one cycle later, and it stays on the outputs until the consumer takes it. There are no flag or status outputs, and no arithmetic condition is signalled.

Top module: `sha512_msg_sigma0`

## Requirements
- R1: For lanes 0, 1 and 2 (bits 64i+63 down to 64i of `in_dst`), result lane i equals dst lane i plus sigma0(dst lane i+1).
- R2: Result lane 3 equals dst lane 3 plus sigma0 of `in_src` bits 63:0.
- R3: `in_src` bits 127:64 have no effect on the result.
- R4: sigma0(x) is rotate-right(x,1) XOR rotate-right(x,8) XOR logical-shift-right(x,7). Bits rotated out of the low end re-enter at bit 63, and bits shifted out by the shift are lost.
- R5: Each lane sum is taken modulo 2^64, and no carry passes from one lane into the next.
- R6: In the cycle after a clock edge with `rst` high, `out_valid` is 0.
- R7: An operand pair accepted at a clock edge appears on `out_data` with `out_valid` high after that same edge, and is presented from then on.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. An `in_valid` offered then is not taken.
- R10: With `out_ready` high and no new operand accepted, `out_valid` falls to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_dst | input | 256 | Four message words, lane 0 in bits 63:0 |
| in_src | input | 128 | Bits 63:0 hold the fifth word; bits 127:64 unused |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Four updated words, lane 0 in bits 63:0 |

## Verification
The only internal state is the output register and its valid flag. A wrong rotate or shift amount, a swapped neighbour, or a lane carry leak shows up as a mismatched word on `out_data` in the first cycle after acceptance. The corner words are chosen to expose these faults: all-zeros, all-ones, and single set bits at every position of every word. A lost or duplicated valid bit shows on `out_valid` or `in_ready` within one cycle. A stall exercise also confirms that a held result neither changes nor gets overwritten by a fresh offer.

// File: rtl/sha512_sched_pkg.sv
package sha512_sched_pkg;
   localparam int unsigned DEF_WORD_W = 64;
   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_ROT_A  = 1;
   localparam int unsigned DEF_ROT_B  = 8;
   localparam int unsigned DEF_SHR_C  = 7;
   localparam int unsigned DEF_SRC_WORDS = 2;
endpackage

// File: rtl/sched_sigma0.sv
module sched_sigma0 #(
   parameter int unsigned WORD_W = sha512_sched_pkg::DEF_WORD_W,
   parameter int unsigned ROT_A  = sha512_sched_pkg::DEF_ROT_A,
   parameter int unsigned ROT_B  = sha512_sched_pkg::DEF_ROT_B,
   parameter int unsigned SHR_C  = sha512_sched_pkg::DEF_SHR_C
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] mix_o
);
   logic [WORD_W-1:0] rot_a_w, rot_b_w, shr_w;

   generate
      if (ROT_A == 0 || ROT_A >= WORD_W) begin : g_bad_a
         $error("sched_sigma0: ROT_A out of range");
      end
      if (ROT_B == 0 || ROT_B >= WORD_W) begin : g_bad_b
         $error("sched_sigma0: ROT_B out of range");
      end
      if (SHR_C >= WORD_W) begin : g_bad_c
         $error("sched_sigma0: SHR_C out of range");
      end
   endgenerate

   // constant amounts: pure wiring
   assign rot_a_w = {word_i[ROT_A-1:0], word_i[WORD_W-1:ROT_A]};
   assign rot_b_w = {word_i[ROT_B-1:0], word_i[WORD_W-1:ROT_B]};
   assign shr_w   = word_i >> SHR_C;
   assign mix_o   = rot_a_w ^ rot_b_w ^ shr_w;
endmodule

// File: rtl/sched_lane.sv
module sched_lane #(
   parameter int unsigned WORD_W = sha512_sched_pkg::DEF_WORD_W
) (
   input  logic [WORD_W-1:0] own_i,
   input  logic [WORD_W-1:0] next_i,
   output logic [WORD_W-1:0] sum_o
);
   logic [WORD_W-1:0] mix_w;

   sched_sigma0 #(.WORD_W(WORD_W)) u_sig (
      .word_i (next_i),
      .mix_o  (mix_w)
   );

   // R5: width-limited add, carry out discarded
   assign sum_o = own_i + mix_w;
endmodule

// File: rtl/sched_out_stage.sv
module sched_out_stage #(
   parameter int unsigned DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   logic take_w;

   generate
      if (DATA_W == 0) begin : g_bad_w
         $error("sched_out_stage: DATA_W must be nonzero");
      end
   endgenerate

   assign in_ready = !out_valid || out_ready;
   assign take_w   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (take_w) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take_w) out_data <= in_data;
   end

   // R6
   valid_clear_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);
   // R7
   accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);
   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R9
   stall_block_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);
   // R10
   drain_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/sha512_msg_sigma0.sv
module sha512_msg_sigma0 #(
   parameter int unsigned WORD_W    = sha512_sched_pkg::DEF_WORD_W,
   parameter int unsigned LANES     = sha512_sched_pkg::DEF_LANES,
   parameter int unsigned SRC_WORDS = sha512_sched_pkg::DEF_SRC_WORDS
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [LANES*WORD_W-1:0]   in_dst,
   input  logic [SRC_WORDS*WORD_W-1:0] in_src,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [LANES*WORD_W-1:0]   out_data
);
   localparam int unsigned DATA_W = LANES * WORD_W;

   logic [WORD_W-1:0] words_w [LANES+1];
   logic [DATA_W-1:0] sum_w;
   logic [SRC_WORDS*WORD_W-1:0] src_unused_w;

   generate
      if (LANES < 1) begin : g_bad_l
         $error("sha512_msg_sigma0: LANES must be at least 1");
      end
      if (SRC_WORDS < 1) begin : g_bad_s
         $error("sha512_msg_sigma0: SRC_WORDS must be at least 1");
      end
   endgenerate

   // R3: only the low word of the narrow operand is used
   assign src_unused_w = in_src;
   assign words_w[LANES] = src_unused_w[WORD_W-1:0];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign words_w[g] = in_dst[g*WORD_W +: WORD_W];
         // R1, R2: lane g pairs with word g+1
         sched_lane #(.WORD_W(WORD_W)) u_lane (
            .own_i  (words_w[g]),
            .next_i (words_w[g+1]),
            .sum_o  (sum_w[g*WORD_W +: WORD_W])
         );
      end
   endgenerate

   sched_out_stage #(.DATA_W(DATA_W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (sum_w),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );
endmodule

// File: tb/sha512_msg_sigma0_bench.sv
module sha512_msg_sigma0_bench;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_ready;
   logic [255:0] in_dst;
   logic [127:0] in_src;
   logic         out_valid;
   logic         out_ready;
   logic [255:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   sha512_msg_sigma0 u_sha512_msg_sigma0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [63:0] mix(input logic [63:0] x);
      logic [63:0] a, b, c;
      a = {x[0], x[63:1]};
      b = {x[7:0], x[63:8]};
      c = {7'b0, x[63:7]};
      return a ^ b ^ c;
   endfunction

   function automatic logic [255:0] model(input logic [255:0] d, input logic [63:0] w4);
      logic [63:0] w [5];
      logic [255:0] r;
      for (int i = 0; i < 4; i++) w[i] = d[64*i +: 64];
      w[4] = w4;
      for (int i = 0; i < 4; i++) r[64*i +: 64] = w[i] + mix(w[i+1]);
      return r;
   endfunction

   task automatic check1(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // apply one operand pair with out_ready high; check one cycle later
   task automatic run(input string req, input logic [255:0] d, input logic [127:0] s);
      @(negedge clk);
      in_valid = 1'b1; in_dst = d; in_src = s;
      @(negedge clk);
      in_valid = 1'b0;
      check1({req, " R7 valid"}, {255'b0, out_valid}, 256'd1);
      check1(req, out_data, model(d, s[63:0]));
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      finish_up();
   end

   initial begin
      logic [255:0] d, held;
      logic [127:0] s;
      rst = 1'b1; in_valid = 1'b0; in_dst = '0; in_src = '0; out_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R6
      check1("R6 reset", {255'b0, out_valid}, 256'd0);
      rst = 1'b0;

      // R4 zeros / ones
      run("R4 zeros", '0, '0);
      run("R4 ones", '1, '1);
      // R5 ones in dst, single bit next word: carries must stay in lane
      run("R5 carry", '1, 128'd1);

      // R1/R2/R4: single-bit word at every position of every word
      for (int w = 0; w < 5; w++) begin
         for (int b = 0; b < 64; b++) begin
            d = '0; s = '0;
            if (w < 4) d[64*w + b] = 1'b1; else s[b] = 1'b1;
            run(w < 4 ? "R1 R4 bit" : "R2 R4 bit", d, s);
         end
      end

      // R10: drained with no new offer
      @(negedge clk);
      check1("R10 drain", {255'b0, out_valid}, 256'd0);

      // R1/R2/R5 random
      for (int k = 0; k < 300; k++) begin
         for (int j = 0; j < 8; j++) d[32*j +: 32] = $urandom;
         for (int j = 0; j < 4; j++) s[32*j +: 32] = $urandom;
         run("R1 R2 R5 random", d, s);
         // R3: change upper src, same result expected
         s[127:64] = ~s[127:64];
         run("R3 upper ignored", d, s);
      end

      // R8/R9 stall
      for (int j = 0; j < 8; j++) d[32*j +: 32] = $urandom;
      s = {64'hDEAD_BEEF_0000_FFFF, 64'h0123_4567_89AB_CDEF};
      held = model(d, s[63:0]);
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_dst = d; in_src = s;
      @(negedge clk);
      in_dst = ~d; in_src = ~s;   // offered while stalled
      for (int c = 0; c < 4; c++) begin
         check1("R9 in_ready low", {255'b0, in_ready}, 256'd0);
         check1("R8 valid held", {255'b0, out_valid}, 256'd1);
         check1("R8 data held", out_data, held);
         @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      check1("R9 not taken", out_data, held);
      @(negedge clk);
      check1("R10 drained", {255'b0, out_valid}, 256'd0);

      // R6 reset mid-stream
      @(negedge clk);
      in_valid = 1'b1; in_dst = d; in_src = s;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check1("R6 reset clears", {255'b0, out_valid}, 256'd0);
      rst = 1'b0;
      @(negedge clk);
      finish_up();
   end
endmodule